// File: doc/BRIEF.md
# Thresholded Event Counter Bank

This block holds a small bank of performance counters. Each counter has its own 32-bit control word that picks one event group out of a set of event inputs and a mask of the subevent lines inside that group. In every cycle the number of masked lines that are active forms a raw increment. A threshold compare and an optional rising-edge detector, placed one after the other, shape that increment before it is added to a 44-bit count. When a count carries out of its top bit it wraps and keeps counting. If overflow reporting is enabled for that counter, a sticky status bit is set and a one-cycle overflow message pulse goes to a global unit.

Software reaches the bank through a plain single-cycle register port. A write is taken on the clock edge while `reg_we` is high. Reads are combinational from `reg_addr`. The port accepts one access per cycle and never stalls, so it carries no valid/ready handshake and no back-pressure. The `freeze` input comes from a global controller and halts all counting without touching the counts.

Top module: `perf_ctr_bank`

## Requirements
- R1: Each count is 44 bits wide. A carry out of bit 43 wraps the count modulo 2^44, and counting goes on after the wrap.
- R2: Register map with NUM_CTR=4: addresses 0..3 are control words, 4..7 are counts, 8 is overflow status, and all other addresses read 0. The control word keeps thresh [31:24], en [22], ov_en [20], edge_det [18], umask [15:8] and ev_sel [7:0]. Bits 23, 21, 19, 17 and 16 are dropped on write and read back 0, so writing all ones reads back 0xFF54FFFF.
- R3: With thresh 0, the per-cycle increment is the number of set bits in (group lines AND umask). Group g is ev_lines[8g+7:8g] and is chosen by ev_sel == g. An ev_sel of NUM_GRP or above gives 0.
- R4: With a non-zero thresh, the counter adds 1 in a cycle where the raw increment is at least thresh, and 0 otherwise.
- R5: With edge_det set, the counter adds 1 only in a cycle where the shaped value is non-zero and was zero in the cycle before. A level that stays high adds only once.
- R6: Writing a control word with bit 17 set clears that counter to 0. Bit 17 reads back 0.
- R7: A counter changes only while its en bit is 1 and freeze is 0.
- R8: A count can be read while it is counting. A write to a count loads the written value and takes priority over counting in the same cycle.
- R9: When a counter with ov_en set wraps, status bit i is set and ov_msg[i] is high for exactly one cycle, from the edge of the wrap onward. With ov_en clear, a wrap sets neither.
- R10: Status bits [3:0] are sticky. Writing 1 to a bit clears it, writing 0 leaves it, and bits 31:4 read 0. A set in the same cycle wins over a clear.
- R11: After reset, all control words, counts and status read 0, and ov_msg is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze | input | 1 | Global halt of all counting |
| ev_lines | input | 32 | Event lines, NUM_GRP groups of GRP_W lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 44 | Write data |
| reg_rdata | output | 44 | Read data, combinational from reg_addr |
| ov_msg | output | 4 | One-cycle overflow message per counter |

## Verification
The bench builds the bank with its default parameters: four counters, four event groups of eight lines, and a full 44-bit count. It reaches the wrap by preloading counts just below 2^44 and does not rely on a narrowed count, so the carry out of bit 43 itself gets exercised. With eight lines per group a raw increment can reach 8, which puts multi-count increments, partial masks and threshold comparisons above 1 within reach, along with an ev_sel value that has no matching group.

// File: rtl/perf_bank_pkg.sv
package perf_bank_pkg;

  localparam int CTL_W    = 32;
  localparam int THR_LO   = 24;
  localparam int EN_BIT   = 22;
  localparam int OVEN_BIT = 20;
  localparam int EDGE_BIT = 18;
  localparam int CLR_BIT  = 17;
  localparam int MASK_LO  = 8;
  localparam int SEL_LO   = 0;

  typedef struct packed {
    logic [7:0] thresh;
    logic       en;
    logic       ov_en;
    logic       edge_det;
    logic [7:0] umask;
    logic [7:0] ev_sel;
  } ctl_t;

  function automatic ctl_t unpack_ctl(input logic [CTL_W-1:0] w);
    ctl_t c;
    c.thresh   = w[THR_LO +: 8];
    c.en       = w[EN_BIT];
    c.ov_en    = w[OVEN_BIT];
    c.edge_det = w[EDGE_BIT];
    c.umask    = w[MASK_LO +: 8];
    c.ev_sel   = w[SEL_LO +: 8];
    return c;
  endfunction

  function automatic logic [CTL_W-1:0] pack_ctl(input ctl_t c);
    logic [CTL_W-1:0] w;
    w = '0;
    w[THR_LO +: 8]  = c.thresh;
    w[EN_BIT]       = c.en;
    w[OVEN_BIT]     = c.ov_en;
    w[EDGE_BIT]     = c.edge_det;
    w[MASK_LO +: 8] = c.umask;
    w[SEL_LO +: 8]  = c.ev_sel;
    return w;
  endfunction

endpackage

// File: rtl/evt_select.sv
module evt_select #(
  parameter int NUM_GRP = 4,
  parameter int GRP_W   = 8,
  localparam int RAW_W  = $clog2(GRP_W + 1)
) (
  input  logic [NUM_GRP*GRP_W-1:0] ev_lines,
  input  logic [7:0]               ev_sel,
  input  logic [GRP_W-1:0]         umask,
  output logic [RAW_W-1:0]         raw
);

  logic [GRP_W-1:0] picked;
  logic [GRP_W-1:0] masked;

  always_comb begin
    picked = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (ev_sel == 8'(g)) picked = ev_lines[g*GRP_W +: GRP_W];
    end
    masked = picked & umask;
  end

  always_comb begin
    raw = '0;
    for (int b = 0; b < GRP_W; b++) begin
      raw = raw + RAW_W'(masked[b]);
    end
  end

endmodule

// File: rtl/evt_shaper.sv
module evt_shaper #(
  parameter int RAW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RAW_W-1:0] raw,
  input  logic [7:0]       thresh,
  input  logic             edge_det,
  output logic [RAW_W-1:0] inc
);

  logic [RAW_W-1:0] level;
  logic             hot;
  logic             prev_q;

  always_comb begin
    if (thresh == 8'd0) level = raw;
    else                level = RAW_W'(32'(raw) >= 32'(thresh));
    hot = (level != '0);
    inc = edge_det ? RAW_W'(hot && !prev_q) : level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= hot;
  end

  AST_THRESH_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh != 8'd0) |-> (inc <= RAW_W'(1))); // R4

  AST_EDGE_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_det && inc != '0) |=> (!edge_det || inc == '0)); // R5

endmodule

// File: rtl/ctr_slice.sv
module ctr_slice
  import perf_bank_pkg::*;
#(
  parameter int CNT_W   = 44,
  parameter int NUM_GRP = 4,
  parameter int GRP_W   = 8,
  localparam int RAW_W  = $clog2(GRP_W + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     freeze,
  input  logic [NUM_GRP*GRP_W-1:0] ev_lines,
  input  logic                     ctl_we,
  input  logic                     cnt_we,
  input  logic [CNT_W-1:0]         wdata,
  output logic [CTL_W-1:0]         ctl_rd,
  output logic [CNT_W-1:0]         cnt_q,
  output logic                     ov_hit,
  output logic                     ov_msg_q
);

  ctl_t             ctl_q;
  logic [RAW_W-1:0] raw;
  logic [RAW_W-1:0] inc;
  logic [CNT_W:0]   sum;
  logic             adv;
  logic             clr_hit;

  evt_select #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) u_sel (
    .ev_lines (ev_lines),
    .ev_sel   (ctl_q.ev_sel),
    .umask    (ctl_q.umask[GRP_W-1:0]),
    .raw      (raw)
  );

  evt_shaper #(.RAW_W(RAW_W)) u_shp (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw      (raw),
    .thresh   (ctl_q.thresh),
    .edge_det (ctl_q.edge_det),
    .inc      (inc)
  );

  always_comb begin
    clr_hit = ctl_we && wdata[CLR_BIT];
    adv     = ctl_q.en && !freeze;
    sum     = {1'b0, cnt_q} + (CNT_W+1)'(inc);
    ov_hit  = adv && !cnt_we && !clr_hit && sum[CNT_W] && ctl_q.ov_en;
    ctl_rd  = pack_ctl(ctl_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_we) begin
      ctl_q <= unpack_ctl(wdata[CTL_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= wdata;
    end else if (clr_hit) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ov_msg_q <= 1'b0;
    else        ov_msg_q <= ov_hit;
  end

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_q == $past(wdata))); // R8

  AST_CLEAR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && wdata[CLR_BIT] && !cnt_we) |=> (cnt_q == '0)); // R6

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !cnt_we && !(ctl_we && wdata[CLR_BIT])) |=> $stable(cnt_q)); // R7

  AST_MSG_NEEDS_OVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ov_msg_q |-> $past(ctl_q.ov_en)); // R9

  AST_MSG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ov_msg_q |=> !ov_msg_q); // R9

endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
  import perf_bank_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CNT_W   = 44,
  parameter int NUM_GRP = 4,
  parameter int GRP_W   = 8,
  localparam int ADDR_W = $clog2(2*NUM_CTR + 1),
  localparam int EV_W   = NUM_GRP * GRP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  logic [EV_W-1:0]   ev_lines,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic [NUM_CTR-1:0] ov_msg
);

  logic [CTL_W-1:0]   ctl_rd [NUM_CTR];
  logic [CNT_W-1:0]   cnt_rd [NUM_CTR];
  logic [NUM_CTR-1:0] ctl_we;
  logic [NUM_CTR-1:0] cnt_we;
  logic [NUM_CTR-1:0] ov_hit;
  logic [NUM_CTR-1:0] status_q;
  logic               st_we;

  assign st_we = reg_we && (reg_addr == ADDR_W'(2*NUM_CTR));

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign ctl_we[i] = reg_we && (reg_addr == ADDR_W'(i));
    assign cnt_we[i] = reg_we && (reg_addr == ADDR_W'(NUM_CTR + i));

    ctr_slice #(
      .CNT_W   (CNT_W),
      .NUM_GRP (NUM_GRP),
      .GRP_W   (GRP_W)
    ) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .freeze   (freeze),
      .ev_lines (ev_lines),
      .ctl_we   (ctl_we[i]),
      .cnt_we   (cnt_we[i]),
      .wdata    (reg_wdata),
      .ctl_rd   (ctl_rd[i]),
      .cnt_q    (cnt_rd[i]),
      .ov_hit   (ov_hit[i]),
      .ov_msg_q (ov_msg[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           status_q[i] <= 1'b0;
      else if (ov_hit[i])                   status_q[i] <= 1'b1;
      else if (st_we && reg_wdata[i])       status_q[i] <= 1'b0;
    end

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[i] && !(st_we && reg_wdata[i])) |=> status_q[i]); // R10

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_we && reg_wdata[i] && !ov_hit[i]) |=> !status_q[i]); // R10

    AST_MSG_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      ov_msg[i] |-> status_q[i] || $past(st_we && reg_wdata[i])); // R9
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (reg_addr == ADDR_W'(i))           reg_rdata = CNT_W'(ctl_rd[i]);
      if (reg_addr == ADDR_W'(NUM_CTR + i)) reg_rdata = cnt_rd[i];
    end
    if (reg_addr == ADDR_W'(2*NUM_CTR))     reg_rdata = CNT_W'(status_q);
  end

endmodule

// File: tb/perf_ctr_bank_test.sv
module perf_ctr_bank_test;

  localparam logic [43:0] TOP = 44'hFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        freeze = 1'b1;
  logic [31:0] ev_lines = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [43:0] reg_wdata = '0;
  logic [43:0] reg_rdata;
  logic [3:0]  ov_msg;

  int checks = 0;
  int errors = 0;
  int msg_cnt [4];
  bit done = 1'b0;

  always #5 clk = ~clk;

  perf_ctr_bank uut (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .ev_lines(ev_lines),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ov_msg(ov_msg)
  );

  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) if (ov_msg[i] === 1'b1) msg_cnt[i]++;
  end

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic logic [43:0] mk(input logic [7:0] thr, input logic en,
                                     input logic oven, input logic edg,
                                     input logic [7:0] um, input logic [7:0] sel);
    return 44'({thr, 1'b0, en, 1'b0, oven, 1'b0, edg, 1'b0, 1'b0, um, sel});
  endfunction

  task automatic wr(input logic [3:0] a, input logic [43:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [43:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    freeze = 1'b0;
    repeat (n) @(negedge clk);
    freeze = 1'b1;
  endtask

  task automatic t_reset;
    logic [43:0] v;
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v);
      check("R11 reset read", v, 0);
    end
    check("R11 reset ov_msg", ov_msg, 0);
  endtask

  task automatic t_map;
    logic [43:0] v;
    wr(0, 44'hFFFF_FFFF);
    rd(0, v);
    check("R2 control mask", v, 44'hFF54_FFFF);
    wr(0, 0);
    rd(12, v);
    check("R2 unmapped read", v, 0);
  endtask

  task automatic t_raw;
    logic [43:0] v;
    ev_lines = 32'h0000_FF00;
    wr(4, 0);
    wr(0, mk(0, 1, 0, 0, 8'h0F, 1));
    run(5);
    rd(4, v);
    check("R3 popcount 4 x5", v, 20);
    ev_lines = 32'h0000_3C00;
    wr(4, 0);
    wr(0, mk(0, 1, 0, 0, 8'hA5, 1));
    run(3);
    rd(4, v);
    check("R3 partial mask", v, 6);
    wr(4, 0);
    wr(0, mk(0, 1, 0, 0, 8'hFF, 7));
    run(4);
    rd(4, v);
    check("R3 no such group", v, 0);
  endtask

  task automatic t_thresh;
    logic [43:0] v;
    ev_lines = 32'h0007_0000;
    wr(4, 0);
    wr(0, mk(3, 1, 0, 0, 8'hFF, 2));
    run(4);
    rd(4, v);
    check("R4 at threshold", v, 4);
    ev_lines = 32'h0003_0000;
    wr(4, 0);
    run(4);
    rd(4, v);
    check("R4 below threshold", v, 0);
  endtask

  task automatic t_edge;
    logic [43:0] v;
    logic [7:0] pat [8] = '{8'h01, 8'hFF, 8'h00, 8'h03, 8'h00, 8'h00, 8'h01, 8'h01};
    ev_lines = '0;
    wr(4, 0);
    wr(0, mk(1, 1, 0, 1, 8'hFF, 3));
    @(negedge clk);
    freeze = 1'b0;
    for (int k = 0; k < 8; k++) begin
      ev_lines = {pat[k], 24'h0};
      @(negedge clk);
    end
    freeze = 1'b1;
    ev_lines = '0;
    rd(4, v);
    check("R5 rising edges", v, 3);
  endtask

  task automatic t_gate;
    logic [43:0] v;
    ev_lines = 32'h0000_FF00;
    wr(4, 0);
    wr(0, mk(0, 0, 0, 0, 8'hFF, 1));
    run(5);
    rd(4, v);
    check("R7 en clear", v, 0);
    wr(0, mk(0, 1, 0, 0, 8'hFF, 1));
    repeat (5) @(negedge clk);
    rd(4, v);
    check("R7 frozen", v, 0);
  endtask

  task automatic t_clear;
    logic [43:0] v;
    wr(4, 20);
    wr(0, mk(0, 1, 0, 0, 8'hFF, 1) | 44'h2_0000);
    rd(4, v);
    check("R6 clear bit", v, 0);
    rd(0, v);
    check("R6 bit17 reads 0", v & 44'h2_0000, 0);
  endtask

  task automatic t_prio;
    logic [43:0] a;
    logic [43:0] b;
    ev_lines = 32'h0000_FF00;
    wr(4, 0);
    wr(0, mk(0, 1, 0, 0, 8'h0F, 1));
    @(negedge clk);
    freeze = 1'b0;
    rd(4, a);
    @(negedge clk);
    rd(4, b);
    check("R8 read while counting", b - a, 4);
    wr(4, 1000);
    freeze = 1'b1;
    rd(4, a);
    check("R8 write wins", a, 1000);
  endtask

  task automatic t_ovf;
    logic [43:0] v;
    ev_lines = 32'h0000_0001;
    wr(1, mk(0, 1, 1, 0, 8'h01, 0));
    wr(2, mk(0, 1, 0, 0, 8'h01, 0));
    wr(5, TOP - 2);
    wr(6, TOP - 1);
    for (int i = 0; i < 4; i++) msg_cnt[i] = 0;
    run(5);
    @(negedge clk);
    rd(5, v);
    check("R1 wrap keeps counting", v, 2);
    rd(6, v);
    check("R1 wrap without ov_en", v, 3);
    rd(8, v);
    check("R9 status set only with ov_en", v, 4'b0010);
    check("R9 one msg pulse", msg_cnt[1], 1);
    check("R9 no msg without ov_en", msg_cnt[2], 0);
  endtask

  task automatic t_w1c;
    logic [43:0] v;
    wr(3, mk(0, 1, 1, 0, 8'h01, 0));
    wr(7, TOP);
    run(2);
    rd(8, v);
    check("R10 two sticky bits", v, 4'b1010);
    wr(8, 44'h2);
    rd(8, v);
    check("R10 clear one bit", v, 4'b1000);
    wr(8, 44'hFFFF_FFF0);
    rd(8, v);
    check("R10 zeros ignored", v, 4'b1000);
    wr(8, 44'h8);
    rd(8, v);
    check("R10 cleared", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_map;
    t_raw;
    t_thresh;
    t_edge;
    t_gate;
    t_clear;
    t_prio;
    t_ovf;
    t_w1c;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule